// File: doc/BRIEF.md
# E1 National-Bits Data Link Mapper

This block carries the timeslot-0 byte of the non-frame-alignment frames of an E1 CRC-4 multiframe to and from a 2.048 Mbit/s serial backplane channel. A shared timebase supplies the frame number within the 16-frame multiframe, the timeslot number, the bit number within the timeslot and a bit strobe. Every stream is one bit per strobe, in both directions.

On the transmit side, the block collects the byte that arrives on backplane input timeslot 0 during each frame-alignment (even) frame. It places that byte on the line in timeslot 0 of the next odd frame. Insertion takes place only when all five per-Sa-bit source-select fields hold the backplane code. When insertion is off, a default byte goes out instead, with bit position 2 forced to 1. On the receive side, the block always captures line timeslot 0 of every odd frame, whatever the source-select setting. It shows the last captured byte on backplane output timeslot 0 until the next odd frame replaces it. All other bits pass through unchanged.

The strobe acts as the valid qualifier of all four bit streams. The channel is paced by the TDM clock and has no back-pressure, so there is no ready signal. A bit counts as transferred only in a cycle in which `bit_stb` is high. Cycles without the strobe change no state.

Top module: `e1_nfas_mapper`

## Requirements
- R1: After reset, both held bytes are zero. Backplane output timeslot 0 reads 0, and with insertion enabled the line output timeslot 0 of odd frames reads 0 until a byte has been collected.
- R2: When `sa_sel` holds 2'b10 in every one of its five 2-bit fields, line output timeslot 0 of an odd frame (`frm_num[0]`=1) carries the byte collected from backplane input timeslot 0 of the preceding even frame. Bit number n (0 first) of the backplane timeslot appears as bit number n of the line timeslot.
- R3: When any source-select field differs from 2'b10, line output timeslot 0 of odd frames carries `dflt_byte`, sent MSB first (bit number n is `dflt_byte[7-n]`), except that bit number 1 (position 2) is always 1.
- R4: In even frames, line output timeslot 0 equals `tx_line_in`.
- R5: In timeslots 1 to 31 of every frame, `tx_line_out` equals `tx_line_in`.
- R6: The byte on line input timeslot 0 of each odd frame is collected in bit order and driven on `bp_out` in timeslot 0 of every later frame (bit number n is the nth received bit), until the next odd frame completes. This happens whatever `sa_sel` holds. Only strobed cycles transfer bits.
- R7: Line input timeslot 0 of even frames has no effect on `bp_out`.
- R8: In timeslots 1 to 31, `bp_out` equals `bp_thru_in`.
- R9: Backplane input during odd frames has no effect on the transmitted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | Bit strobe; qualifies all serial streams |
| frm_num | input | 4 | Frame number in the CRC-4 multiframe |
| ts_num | input | 5 | Timeslot number |
| bit_num | input | 3 | Bit number within timeslot, 0 sent first |
| sa_sel | input | 10 | Five 2-bit source-select fields |
| dflt_byte | input | 8 | Byte sent in odd-frame timeslot 0 when insertion is off |
| bp_in | input | 1 | Backplane input stream |
| tx_line_in | input | 1 | Transmit line stream from upstream |
| tx_line_out | output | 1 | Transmit line stream with insertion |
| rx_line_in | input | 1 | Receive line stream |
| bp_thru_in | input | 1 | Backplane output stream from upstream |
| bp_out | output | 1 | Backplane output stream with extracted byte |

## Verification
The hardest case to reach from the ports is a held byte that must survive input it should ignore. This includes backplane data in odd frames, line data in even frames and the cycles without a strobe, none of which may leave a trace. The bench strobes every other clock and drives complemented data in every cycle without a strobe. It also drives complemented bytes into the timeslot-0 positions that the block must not capture. Several whole multiframes are swept with insertion on, off through one wrong field, and off through all fields. This shows whether any stray capture reached an output.

// File: rtl/e1n_pkg.sv
package e1n_pkg;
  typedef enum logic [1:0] {
    SRC_OFF  = 2'b00,
    SRC_ALT  = 2'b01,
    SRC_BP   = 2'b10,
    SRC_RSV  = 2'b11
  } sa_src_e;
endpackage

// File: rtl/nfas_slot_decode.sv
module nfas_slot_decode #(
  parameter int FW  = 4,
  parameter int TW  = 5,
  parameter int BSW = 3,
  parameter int BITS = 8
) (
  input  logic [FW-1:0]  frm_num,
  input  logic [TW-1:0]  ts_num,
  input  logic [BSW-1:0] bit_num,
  output logic           ts0,
  output logic           nfas_ts0,
  output logic           fas_ts0,
  output logic           last_bit,
  output logic [BSW-1:0] bit_sel
);
  always_comb begin
    ts0      = (ts_num == '0);
    nfas_ts0 = ts0 && frm_num[0];
    fas_ts0  = ts0 && !frm_num[0];
    last_bit = (bit_num == BSW'(BITS-1));
    bit_sel  = BSW'(BITS-1) - bit_num;
  end
endmodule

// File: rtl/nfas_tx_insert.sv
module nfas_tx_insert
  import e1n_pkg::*;
#(
  parameter int BITS      = 8,
  parameter int SA_FIELDS = 5,
  parameter int FORCE_POS = 1,
  localparam int BSW = $clog2(BITS),
  localparam int SW  = 2*SA_FIELDS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_stb,
  input  logic           fas_ts0,
  input  logic           nfas_ts0,
  input  logic           last_bit,
  input  logic [BSW-1:0] bit_sel,
  input  logic [SW-1:0]  sa_sel,
  input  logic [BITS-1:0] dflt_byte,
  input  logic           bp_in,
  input  logic           tx_line_in,
  output logic           tx_line_out
);
  localparam logic [BITS-1:0] FORCE_MASK = BITS'(1) << (BITS-1-FORCE_POS);

  logic [SA_FIELDS-1:0] fld_bp;
  logic                 ins_en;
  logic [BITS-1:0]      cap_sr;
  logic [BITS-1:0]      tx_hold;
  logic [BITS-1:0]      dflt_eff;

  for (genvar g = 0; g < SA_FIELDS; g++) begin : g_fld
    assign fld_bp[g] = (sa_sel[2*g +: 2] == SRC_BP);
  end

  assign ins_en   = &fld_bp;
  assign dflt_eff = dflt_byte | FORCE_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_sr  <= '0;
      tx_hold <= '0;
    end else if (bit_stb && fas_ts0) begin
      cap_sr <= {cap_sr[BITS-2:0], bp_in};
      if (last_bit) tx_hold <= {cap_sr[BITS-2:0], bp_in};
    end
  end

  always_comb begin
    tx_line_out = tx_line_in;
    if (nfas_ts0) tx_line_out = ins_en ? tx_hold[bit_sel] : dflt_eff[bit_sel];
  end

  p_tx_hold_odd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fas_ts0 || !bit_stb) |=> $stable(tx_hold));
  p_tx_hold_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && fas_ts0 && !last_bit) |=> $stable(tx_hold));
  p_force_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_en && nfas_ts0 && bit_sel == BSW'(BITS-1-FORCE_POS)) |-> tx_line_out);
endmodule

// File: rtl/nfas_rx_extract.sv
module nfas_rx_extract #(
  parameter int BITS = 8,
  localparam int BSW = $clog2(BITS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_stb,
  input  logic           ts0,
  input  logic           nfas_ts0,
  input  logic           last_bit,
  input  logic [BSW-1:0] bit_sel,
  input  logic           rx_line_in,
  input  logic           bp_thru_in,
  output logic           bp_out
);
  logic [BITS-1:0] rx_sr;
  logic [BITS-1:0] rx_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sr   <= '0;
      rx_hold <= '0;
    end else if (bit_stb && nfas_ts0) begin
      rx_sr <= {rx_sr[BITS-2:0], rx_line_in};
      if (last_bit) rx_hold <= {rx_sr[BITS-2:0], rx_line_in};
    end
  end

  assign bp_out = ts0 ? rx_hold[bit_sel] : bp_thru_in;

  p_rx_hold_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!nfas_ts0 || !bit_stb) |=> $stable(rx_hold));
  p_rx_hold_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && nfas_ts0 && !last_bit) |=> $stable(rx_hold));
  p_rx_sr_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(rx_sr));
endmodule

// File: rtl/e1_nfas_mapper.sv
module e1_nfas_mapper #(
  parameter int FRAMES    = 16,
  parameter int SLOTS     = 32,
  parameter int BITS      = 8,
  parameter int SA_FIELDS = 5,
  parameter int FORCE_POS = 1,
  localparam int FW  = $clog2(FRAMES),
  localparam int TW  = $clog2(SLOTS),
  localparam int BSW = $clog2(BITS),
  localparam int SW  = 2*SA_FIELDS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_stb,
  input  logic [FW-1:0]   frm_num,
  input  logic [TW-1:0]   ts_num,
  input  logic [BSW-1:0]  bit_num,
  input  logic [SW-1:0]   sa_sel,
  input  logic [BITS-1:0] dflt_byte,
  input  logic            bp_in,
  input  logic            tx_line_in,
  output logic            tx_line_out,
  input  logic            rx_line_in,
  input  logic            bp_thru_in,
  output logic            bp_out
);
  logic           ts0, nfas_ts0, fas_ts0, last_bit;
  logic [BSW-1:0] bit_sel;

  nfas_slot_decode #(.FW(FW), .TW(TW), .BSW(BSW), .BITS(BITS)) u_dec (
    .frm_num(frm_num), .ts_num(ts_num), .bit_num(bit_num),
    .ts0(ts0), .nfas_ts0(nfas_ts0), .fas_ts0(fas_ts0),
    .last_bit(last_bit), .bit_sel(bit_sel)
  );

  nfas_tx_insert #(.BITS(BITS), .SA_FIELDS(SA_FIELDS), .FORCE_POS(FORCE_POS)) u_tx (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb),
    .fas_ts0(fas_ts0), .nfas_ts0(nfas_ts0), .last_bit(last_bit),
    .bit_sel(bit_sel), .sa_sel(sa_sel), .dflt_byte(dflt_byte),
    .bp_in(bp_in), .tx_line_in(tx_line_in), .tx_line_out(tx_line_out)
  );

  nfas_rx_extract #(.BITS(BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb),
    .ts0(ts0), .nfas_ts0(nfas_ts0), .last_bit(last_bit),
    .bit_sel(bit_sel), .rx_line_in(rx_line_in),
    .bp_thru_in(bp_thru_in), .bp_out(bp_out)
  );

  p_ts_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(nfas_ts0 && fas_ts0));
  p_thru_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_num != '0) |-> (bp_out == bp_thru_in && tx_line_out == tx_line_in));
endmodule

// File: tb/sim_e1_nfas_mapper.sv
module sim_e1_nfas_mapper;
  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n, bit_stb, bp_in, tx_line_in, rx_line_in, bp_thru_in;
  logic [3:0] frm_num;
  logic [4:0] ts_num;
  logic [2:0] bit_num;
  logic [9:0] sa_sel;
  logic [7:0] dflt_byte;
  logic tx_line_out, bp_out;

  e1_nfas_mapper u0 (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .frm_num(frm_num),
    .ts_num(ts_num), .bit_num(bit_num), .sa_sel(sa_sel), .dflt_byte(dflt_byte),
    .bp_in(bp_in), .tx_line_in(tx_line_in), .tx_line_out(tx_line_out),
    .rx_line_in(rx_line_in), .bp_thru_in(bp_thru_in), .bp_out(bp_out)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] e_tx = 0, e_rx = 0, acc_bp = 0, acc_rx = 0;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bpb(int m, int f);
    return 8'(m*53 + f*29 + 7);
  endfunction
  function automatic logic [7:0] rxb(int m, int f);
    return 8'(m*71 + f*13 + 165);
  endfunction
  function automatic logic hsh(int m, int f, int t, int b, int k);
    return 1'(((m*5 + f*3 + t*7 + b + k) % 3) == 0);
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=100000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0; bit_stb = 0; bp_in = 0; tx_line_in = 0; rx_line_in = 0;
    bp_thru_in = 0; frm_num = 1; ts_num = 0; bit_num = 0;
    sa_sel = 10'b10_10_10_10_10; dflt_byte = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1: held bytes read zero after reset
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      bit_num = 3'(b); tx_line_in = 1; bit_stb = 0;
      #1;
      chk("R1 bp_out ts0", bp_out, 1'b0);
      chk("R1 tx_line_out nfas ts0", tx_line_out, 1'b0);
    end
    for (int m = 0; m < 4; m++) begin
      logic en;
      logic [7:0] dd;
      case (m)
        0: begin sa_sel = 10'b10_10_10_10_10; dflt_byte = 8'h81; end
        1: begin sa_sel = 10'b10_10_11_10_10; dflt_byte = 8'h25; end
        2: begin sa_sel = 10'b10_10_10_10_10; dflt_byte = 8'h00; end
        default: begin sa_sel = 10'b00_00_00_00_00; dflt_byte = 8'h00; end
      endcase
      en = (m == 0 || m == 2);
      dd = dflt_byte | 8'h40;
      for (int f = 0; f < 16; f++)
        for (int t = 0; t < 32; t++)
          for (int b = 0; b < 8; b++) begin
            logic odd, z, ebit;
            odd = f[0];
            z = (t == 0);
            @(negedge clk);
            frm_num = 4'(f); ts_num = 5'(t); bit_num = 3'(b); bit_stb = 1;
            bp_in = z ? (odd ? ~bpb(m, f)[7-b] : bpb(m, f)[7-b]) : hsh(m, f, t, b, 1);
            rx_line_in = z ? (odd ? rxb(m, f)[7-b] : ~rxb(m, f)[7-b]) : hsh(m, f, t, b, 2);
            tx_line_in = hsh(m, f, t, b, 0);
            bp_thru_in = hsh(m, f, t, b, 4);
            #1;
            if (z && odd) begin
              ebit = en ? e_tx[7-b] : dd[7-b];
              if (en) chk("R2 R9 inserted bit", tx_line_out, ebit);
              else    chk("R3 default bit", tx_line_out, ebit);
            end else if (z) chk("R4 fas ts0 pass", tx_line_out, tx_line_in);
            else chk("R5 tx pass", tx_line_out, tx_line_in);
            if (z) chk("R6 R7 bp_out ts0", bp_out, e_rx[7-b]);
            else   chk("R8 bp pass", bp_out, bp_thru_in);
            @(posedge clk);
            if (z && !odd) begin
              acc_bp = {acc_bp[6:0], bp_in};
              if (b == 7) e_tx = acc_bp;
            end
            if (z && odd) begin
              acc_rx = {acc_rx[6:0], rx_line_in};
              if (b == 7) e_rx = acc_rx;
            end
            @(negedge clk);
            bit_stb = 0; bp_in = ~bp_in; rx_line_in = ~rx_line_in;
          end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule